// File: doc/BRIEF.md
# Two-Core Snooping MESI Line Controller

This block keeps one shared memory word coherent between two processor-side caches. Each core has a request port with three commands: read, write with data, and evict. The block tracks each core's copy in one of the four MESI states and stores the cached value beside it. It also holds the backing-memory word. Every command moves data between the caches and memory exactly as the protocol requires. A clean copy is handed from cache to cache. A dirty copy is supplied and written back in the same step.

Only one request is serviced per cycle. When both cores ask in the same cycle, a round-robin arbiter grants one of them. The other core sees its ready signal low and holds its request until it is granted. A granted command takes effect at the clock edge. One cycle later the new states, the values and a response pulse appear, with the requester's cached value on the response data. The block also counts invalidations, cache-to-cache transfers and write-backs. It reports which core, if any, owns the line in M or E.

Top module: `mesi_pair_ctrl`

## Requirements
- R1: After reset both copies are Invalid (state code 0) with value 0, memory is 0, the three counters are 0, owner_vld is 0 and no ready is raised.
- R2: A read from an Invalid copy while the other copy is Invalid loads the memory value and ends Exclusive (code 2), with no counter change.
- R3: A read from an Invalid copy while the other copy is Exclusive or Shared copies the other core's value, leaves both copies Shared (code 1) and adds one to the transfer counter.
- R4: A read from an Invalid copy while the other copy is Modified (code 3) copies that value and also writes it to memory. Both copies end Shared, and the transfer and write-back counters each go up by one.
- R5: A write from an Invalid copy invalidates any valid other copy and adds one to the invalidation counter. If the other copy was Modified, its value is also written to memory and the transfer and write-back counters each go up by one. The requester ends Modified, holding the write data.
- R6: A write to an Exclusive copy changes it to Modified with the new data, leaves memory alone and changes no counter.
- R7: A write to a Shared copy invalidates the other copy and adds one to the invalidation counter when that copy is valid. The requester then becomes Modified with the new data.
- R8: Evicting a Modified copy writes its value to memory and adds one to the write-back counter. Evicting an Exclusive or Shared copy leaves memory unchanged. The evicted copy ends Invalid with value 0, and evicting an Invalid copy changes nothing.
- R9: At most one copy is ever in M or E, and whenever one copy is in M or E the other copy is Invalid.
- R10: At most one ready is high in any cycle, and ready is high only with a valid request. When both cores request in the same cycle, the core other than the last one serviced is granted first (core 0 first after reset). The waiting core is granted in the next cycle.
- R11: A read from a valid copy returns its value on rsp_data and changes no state, value, memory or counter. Command encoding: read 0, write 1, evict 2; code 3 is accepted and does nothing.
- R12: owner_vld is 1 and owner_idx names the core exactly when that core's copy is M or E. Otherwise owner_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 2 | Request valid, bit i for core i |
| req_op | input | 4 | Command per core, bits [2i+1:2i] |
| req_wdata | input | 2*DW | Write data per core, slice i |
| req_rdy | output | 2 | Grant; request accepted at this edge |
| rsp_vld | output | 2 | One-cycle pulse for the serviced core |
| rsp_data | output | DW | Requester's cached value after the command |
| line_state | output | 4 | Per-core state, bits [2i+1:2i] |
| line_value | output | 2*DW | Per-core cached value, slice i |
| mem_value | output | DW | Backing-memory word |
| owner_vld | output | 1 | A core holds the line in M or E |
| owner_idx | output | 1 | Index of that core |
| inv_cnt | output | CW | Invalidation count |
| xfer_cnt | output | CW | Cache-to-cache transfer count |
| wb_cnt | output | CW | Write-back count |

## Verification
Each command is driven against every state the other core can hold. Reads against an Invalid, a clean and a dirty partner show the memory fetch, the clean transfer and the transfer with write-back as three separate results. Writes from E, from S with a valid partner, from S with an invalid partner, and from I with a Modified or a Shared partner show which of them invalidate and which also write back. Evicts from M, from S and from I show the write-back and the no-op. Simultaneous requests, one pair needing bus work and one pair made of a hit and an evict, show the grant order and that the held request is serviced afterwards.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  localparam int NCORE = 2;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NOP   = 2'd3
  } op_e;
endpackage

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] gnt,
  output logic       gnt_idx,
  output logic       fire
);
  logic prio_q, prio_d, prio_en;

  always_comb begin
    if (req == 2'b11) gnt = prio_q ? 2'b10 : 2'b01;
    else              gnt = req;
    gnt_idx = gnt[1];
    fire    = |gnt;
    prio_en = fire;
    prio_d  = ~gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_q <= 1'b0;
    else if (prio_en) prio_q <= prio_d;
  end
endmodule

// File: rtl/mesi_txn_engine.sv
module mesi_txn_engine
  import mesi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                fire,
  input  logic                req_idx,
  input  logic [1:0]          op,
  input  logic [DW-1:0]       wdata,
  input  logic [1:0][1:0]     st,
  input  logic [1:0][DW-1:0]  val,
  input  logic [DW-1:0]       mem,
  output logic [1:0][1:0]     st_n,
  output logic [1:0][DW-1:0]  val_n,
  output logic [DW-1:0]       mem_n,
  output logic [2:0]          evt_inc,
  output logic [DW-1:0]       rsp_data
);
  logic  r, o;
  mesi_e sr, so;

  always_comb begin
    st_n    = st;
    val_n   = val;
    mem_n   = mem;
    evt_inc = '0;
    r       = req_idx;
    o       = ~req_idx;
    sr      = mesi_e'(st[r]);
    so      = mesi_e'(st[o]);
    if (fire) begin
      unique case (op_e'(op))
        OP_READ: begin
          if (sr == ST_I) begin
            if (so == ST_I) begin
              val_n[r] = mem;
              st_n[r]  = ST_E;
            end else begin
              val_n[r]   = val[o];
              st_n[r]    = ST_S;
              st_n[o]    = ST_S;
              evt_inc[1] = 1'b1;
              if (so == ST_M) begin
                mem_n      = val[o];
                evt_inc[2] = 1'b1;
              end
            end
          end
        end
        OP_WRITE: begin
          if (so != ST_I) begin
            evt_inc[0] = 1'b1;
            st_n[o]    = ST_I;
            val_n[o]   = '0;
            if (so == ST_M) begin
              mem_n      = val[o];
              evt_inc[1] = 1'b1;
              evt_inc[2] = 1'b1;
            end
          end
          st_n[r]  = ST_M;
          val_n[r] = wdata;
        end
        OP_EVICT: begin
          if (sr != ST_I) begin
            if (sr == ST_M) begin
              mem_n      = val[r];
              evt_inc[2] = 1'b1;
            end
            st_n[r]  = ST_I;
            val_n[r] = '0;
          end
        end
        default: ;
      endcase
    end
    rsp_data = val_n[r];
  end
endmodule

// File: rtl/mesi_evt_cnt.sv
module mesi_evt_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/mesi_pair_ctrl.sv
module mesi_pair_ctrl
  import mesi_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_vld,
  input  logic [3:0]        req_op,
  input  logic [2*DW-1:0]   req_wdata,
  output logic [1:0]        req_rdy,
  output logic [1:0]        rsp_vld,
  output logic [DW-1:0]     rsp_data,
  output logic [3:0]        line_state,
  output logic [2*DW-1:0]   line_value,
  output logic [DW-1:0]     mem_value,
  output logic              owner_vld,
  output logic              owner_idx,
  output logic [CW-1:0]     inv_cnt,
  output logic [CW-1:0]     xfer_cnt,
  output logic [CW-1:0]     wb_cnt
);
  localparam int NEVT = 3;

  logic [1:0]           gnt;
  logic                 gnt_idx, fire;
  logic [1:0]           op_sel;
  logic [DW-1:0]        wdata_sel;
  logic [1:0][1:0]      st_q, st_d;
  logic [1:0][DW-1:0]   val_q, val_d;
  logic [DW-1:0]        mem_q, mem_d;
  logic [1:0]           rsp_vld_q, rsp_vld_d;
  logic [DW-1:0]        rsp_data_q, rsp_data_d;
  logic [NEVT-1:0]      evt_inc;
  logic [NEVT-1:0][CW-1:0] evt_cnt;

  mesi_rr_arb u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_vld),
    .gnt(gnt), .gnt_idx(gnt_idx), .fire(fire)
  );

  always_comb begin
    op_sel    = req_op[gnt_idx*2 +: 2];
    wdata_sel = req_wdata[gnt_idx*DW +: DW];
  end

  mesi_txn_engine #(.DW(DW)) u_eng (
    .fire(fire), .req_idx(gnt_idx), .op(op_sel), .wdata(wdata_sel),
    .st(st_q), .val(val_q), .mem(mem_q),
    .st_n(st_d), .val_n(val_d), .mem_n(mem_d),
    .evt_inc(evt_inc), .rsp_data(rsp_data_d)
  );

  always_comb rsp_vld_d = gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      val_q <= '0;
      mem_q <= '0;
    end else if (fire) begin
      st_q  <= st_d;
      val_q <= val_d;
      mem_q <= mem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q  <= '0;
      rsp_data_q <= '0;
    end else begin
      rsp_vld_q <= rsp_vld_d;
      if (fire) rsp_data_q <= rsp_data_d;
    end
  end

  for (genvar g = 0; g < NEVT; g++) begin : g_cnt
    mesi_evt_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(evt_inc[g]), .cnt(evt_cnt[g])
    );
  end

  always_comb begin
    owner_vld = 1'b0;
    owner_idx = 1'b0;
    for (int i = 0; i < NCORE; i++) begin
      if (st_q[i] == ST_M || st_q[i] == ST_E) begin
        owner_vld = 1'b1;
        owner_idx = 1'(i);
      end
    end
  end

  assign req_rdy    = gnt;
  assign rsp_vld    = rsp_vld_q;
  assign rsp_data   = rsp_data_q;
  assign line_state = st_q;
  assign line_value = val_q;
  assign mem_value  = mem_q;
  assign inv_cnt    = evt_cnt[0];
  assign xfer_cnt   = evt_cnt[1];
  assign wb_cnt     = evt_cnt[2];
endmodule

// File: rtl/mesi_pair_chk.sv
module mesi_pair_chk #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      req_vld,
  input logic [3:0]      req_op,
  input logic [1:0]      req_rdy,
  input logic [3:0]      line_state,
  input logic [DW-1:0]   mem_value,
  input logic            owner_vld,
  input logic            owner_idx,
  input logic [CW-1:0]   inv_cnt,
  input logic [CW-1:0]   xfer_cnt,
  input logic [CW-1:0]   wb_cnt
);
  logic [1:0] s0, s1;
  assign s0 = line_state[1:0];
  assign s1 = line_state[3:2];

  // R9
  sole_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((s0[1] && s1 != 2'd0) || (s1[1] && s0 != 2'd0)));

  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_rdy));

  // R10
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rdy & ~req_vld) == 2'b00);

  // R12
  owner_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owner_vld == (s0[1] || s1[1]) &&
    (!owner_vld || line_state[owner_idx*2+1]));

  for (genvar i = 0; i < 2; i++) begin : g_core
    // R6
    silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rdy[i] && req_op[2*i +: 2] == 2'd1 && line_state[2*i +: 2] == 2'd2)
      |=> (line_state[2*i +: 2] == 2'd3 && $stable(inv_cnt) &&
           $stable(xfer_cnt) && $stable(wb_cnt) && $stable(mem_value)));

    // R8
    dirty_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rdy[i] && req_op[2*i +: 2] == 2'd2 && line_state[2*i +: 2] == 2'd3)
      |=> (wb_cnt == $past(wb_cnt) + CW'(1) && line_state[2*i +: 2] == 2'd0));

    // R11
    read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rdy[i] && req_op[2*i +: 2] == 2'd0 && line_state[2*i +: 2] != 2'd0)
      |=> ($stable(line_state) && $stable(mem_value) && $stable(inv_cnt) &&
           $stable(xfer_cnt) && $stable(wb_cnt)));
  end
endmodule

bind mesi_pair_ctrl mesi_pair_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
  .req_rdy(req_rdy), .line_state(line_state), .mem_value(mem_value),
  .owner_vld(owner_vld), .owner_idx(owner_idx), .inv_cnt(inv_cnt),
  .xfer_cnt(xfer_cnt), .wb_cnt(wb_cnt)
);

// File: tb/mesi_pair_ctrl_tb.sv
module mesi_pair_ctrl_tb;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EV = 2'd2;

  logic clk, rst_n;
  logic [1:0] req_vld;
  logic [3:0] req_op;
  logic [2*DW-1:0] req_wdata;
  logic [1:0] req_rdy, rsp_vld;
  logic [DW-1:0] rsp_data, mem_value;
  logic [3:0] line_state;
  logic [2*DW-1:0] line_value;
  logic owner_vld, owner_idx;
  logic [CW-1:0] inv_cnt, xfer_cnt, wb_cnt;

  int n_chk = 0, n_fail = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];

  mesi_pair_ctrl #(.DW(DW), .CW(CW)) u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] snap(logic [1:0] rv, logic [1:0] s0, logic [1:0] s1,
      logic [7:0] v0, logic [7:0] v1, logic [7:0] mem, logic [7:0] inv,
      logic [7:0] xf, logic [7:0] wb, logic ov, logic oi, logic [7:0] rsp);
    return {rv, s0, s1, v0, v1, mem, inv, xf, wb, ov, oi, rsp};
  endfunction

  function automatic logic [63:0] actual();
    return snap(rsp_vld, line_state[1:0], line_state[3:2], line_value[7:0],
                line_value[15:8], mem_value, inv_cnt, xfer_cnt, wb_cnt,
                owner_vld, owner_idx, rsp_data);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_vld != 2'b00) begin
      if (exp_q.size() == 0) check("R10 unexpected response", 64'(rsp_vld), 64'd0);
      else check(tag_q.pop_front(), actual(), exp_q.pop_front());
    end
  end

  task automatic issue(int c, logic [1:0] op, logic [7:0] wd, string tag, logic [63:0] exp);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_vld[c] = 1'b1;
    req_op[2*c +: 2] = op;
    req_wdata[8*c +: 8] = wd;
    @(negedge clk);
    req_vld[c] = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = '0; req_op = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset snapshot", actual(), snap(0, I, I, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    check("R1 no ready", 64'(req_rdy), 64'd0);

    issue(0, RD, 0,    "R2 read miss alone", snap(1, E, I, 0, 0, 0, 0, 0, 0, 1, 0, 0));
    issue(0, WR, 8'h5A,"R6 silent E->M",     snap(1, M, I, 8'h5A, 0, 0, 0, 0, 0, 1, 0, 8'h5A));
    issue(1, RD, 0,    "R4 read vs M",       snap(2, S, S, 8'h5A, 8'h5A, 8'h5A, 0, 1, 1, 0, 0, 8'h5A));
    issue(1, WR, 8'h3C,"R7 write hit S",     snap(2, I, M, 0, 8'h3C, 8'h5A, 1, 1, 1, 1, 1, 8'h3C));
    issue(0, WR, 8'h77,"R5 write miss vs M", snap(1, M, I, 8'h77, 0, 8'h3C, 2, 2, 2, 1, 0, 8'h77));
    issue(0, RD, 0,    "R11 read hit M",     snap(1, M, I, 8'h77, 0, 8'h3C, 2, 2, 2, 1, 0, 8'h77));
    issue(0, EV, 0,    "R8 evict M",         snap(1, I, I, 0, 0, 8'h77, 2, 2, 3, 0, 0, 0));
    issue(1, EV, 0,    "R8 evict I no-op",   snap(2, I, I, 0, 0, 8'h77, 2, 2, 3, 0, 0, 0));
    issue(1, RD, 0,    "R2 refetch",         snap(2, I, E, 0, 8'h77, 8'h77, 2, 2, 3, 1, 1, 8'h77));
    issue(0, RD, 0,    "R3 read vs E",       snap(1, S, S, 8'h77, 8'h77, 8'h77, 2, 3, 3, 0, 0, 8'h77));
    issue(0, EV, 0,    "R8 evict S",         snap(1, I, S, 0, 8'h77, 8'h77, 2, 3, 3, 0, 0, 0));
    issue(0, WR, 8'h11,"R5 write miss vs S", snap(1, M, I, 8'h11, 0, 8'h77, 3, 3, 3, 1, 0, 8'h11));

    // R10 simultaneous: core 1 wins (core 0 served last)
    @(negedge clk);
    exp_q.push_back(snap(2, S, S, 8'h11, 8'h11, 8'h11, 3, 4, 4, 0, 0, 8'h11));
    tag_q.push_back("R10 first grant core1 read vs M");
    exp_q.push_back(snap(1, S, S, 8'h11, 8'h11, 8'h11, 3, 4, 4, 0, 0, 8'h11));
    tag_q.push_back("R10 held core0 read hit");
    req_vld = 2'b11; req_op = {RD, RD};
    #1 check("R10 grant core1 first", 64'(req_rdy), 64'd2);
    @(negedge clk);
    req_vld[1] = 1'b0;
    #1 check("R10 held core0 granted", 64'(req_rdy), 64'd1);
    @(negedge clk);
    req_vld = 2'b00;

    // R10 second pair: core 1 evicts S, then core 0 writes S with no partner (R7)
    exp_q.push_back(snap(2, S, I, 8'h11, 0, 8'h11, 3, 4, 4, 0, 0, 0));
    tag_q.push_back("R10 R8 core1 evict S");
    exp_q.push_back(snap(1, M, I, 8'h22, 0, 8'h11, 3, 4, 4, 1, 0, 8'h22));
    tag_q.push_back("R7 write S no partner");
    req_vld = 2'b11; req_op = {EV, WR}; req_wdata = {8'h00, 8'h22};
    #1 check("R10 grant core1 again", 64'(req_rdy), 64'd2);
    @(negedge clk);
    req_vld[1] = 1'b0;
    #1 check("R10 core0 after wait", 64'(req_rdy), 64'd1);
    @(negedge clk);
    req_vld = 2'b00;

    repeat (3) @(negedge clk);
    check("R10 all responses seen", 64'(exp_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule